// File: doc/BRIEF.md
# ADC Result Bank with Overrun Tracking

This block stores the results of an eight-channel, 10-bit analog-to-digital converter and the status that goes with them. Each time the converter finishes, it presents a one-cycle completion strobe together with the channel number and the 10-bit value. The block files the value into that channel's own result register and into a shared most-recent-result register, and it raises the matching flags in a status word.

Software or a bus bridge reads everything through one register-read port. The read data is combinational from the address. The flag updates caused by a read take effect at the clock edge on which the read strobe is high.

Reading a channel register acknowledges that channel's completion flag. Reading the most-recent-result register acknowledges the global data-ready flag. Reading the status word clears every overrun indication. A completion on a channel that has not been read yet raises an overrun for that channel. A completion while the global data-ready flag is still up raises the global overrun. A per-channel enable mask decides which completion strobes are accepted.

Top module: `adc_result_bank`

## Requirements
- R1: After reset every channel result register, the most-recent-result register and the status word read as zero.
- R2: An accepted completion for channel c writes its 10-bit value into the result register of channel c and sets status bit c, the completion flag of that channel.
- R3: A read of address c, where c is from 0 to 7, returns channel c's result in bits 9:0 with zeros above. On the read edge it clears status bit c.
- R4: A completion for channel c while status bit c is set sets status bit 8+c, the overrun flag of that channel. This does not happen when channel c's result register is read in that same cycle.
- R5: Every accepted completion loads address 8. Address 8 then reads back the value in bits 9:0 and the channel number in bits 12:10. The completion also sets status bit 16, the data-ready flag.
- R6: A read of address 8 clears status bit 16 on the read edge.
- R7: A completion while status bit 16 is set sets status bit 17, the global overrun flag. This does not happen when address 8 is read in that same cycle.
- R8: A read of address 9 returns the status word and clears bits 15:8 and bit 17 on the read edge. Bits 7:0 and bit 16 are left unchanged.
- R9: When a completion sets a flag in the same cycle that a read would clear that flag, the flag ends up set.
- R10: A completion strobe for a channel whose enable bit is low changes no result register and no flag.
- R11: Addresses 10 to 15 read as zero and change nothing. A cycle with the read strobe low changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_en | input | 8 | Per-channel enable mask; bit c enables channel c |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| conv_ch | input | 3 | Channel number of the finished conversion |
| conv_data | input | 10 | Converted value |
| rd_en | input | 1 | Read strobe; the read side effects happen on the edge where it is high |
| rd_addr | input | 4 | Register address: 0-7 channel results, 8 most recent result, 9 status |
| rd_data | output | 32 | Read data for rd_addr |

## Verification
The bench builds the block with its default parameters: eight channels and 10-bit results. With these values the highest channel (7) appears in bits 12:10 of the most-recent-result readback, and the full-scale value 0x3FF is in reach. Status bit 17 and the unmapped addresses 10 to 15 are also reached. The directed tests put a completion and a clearing read in the same cycle for three cases:
- a channel-register read,
- a status read,
- a most-recent-result read.

These cases probe the rule that a set wins and the rule that a same-cycle read avoids an overrun.

// File: rtl/adc_res_pkg.sv
// Package: shared constants and types for the ADC result bank.
// Assumes: read data bus is 32 bits wide; everything else is parameterised
// in the modules that use it.
package adc_res_pkg;

    localparam int unsigned BUS_W = 32;

    // Kind of register selected by a read address.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CHAN = 2'd1,
        SEL_LAST = 2'd2,
        SEL_STAT = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/adc_rd_decode.sv
// Module: read address decoder.
// Classifies a read address as channel result, most-recent result, status or
// unmapped, and produces the clear-on-read strobes qualified by rd_en.
// Assumes: channel registers sit at 0..NUM_CH-1, most-recent at NUM_CH,
// status at NUM_CH+1.
module adc_rd_decode
    import adc_res_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output rd_sel_e           rd_sel,
    output logic [NUM_CH-1:0] chan_rd,
    output logic              last_rd,
    output logic              stat_rd
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CH + 1);

    // Decode the address into a register kind.
    always_comb begin
        if (rd_addr == LAST_ADDR)
            rd_sel = SEL_LAST;
        else if (rd_addr == STAT_ADDR)
            rd_sel = SEL_STAT;
        else if (int'(rd_addr) < NUM_CH)
            rd_sel = SEL_CHAN;
        else
            rd_sel = SEL_NONE;
    end

    // One clear strobe per channel register, only during a real read.
    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chan_rd
        assign chan_rd[gi] = rd_en && (rd_addr == ADDR_W'(gi));
    end

    assign last_rd = rd_en && (rd_sel == SEL_LAST);
    assign stat_rd = rd_en && (rd_sel == SEL_STAT);

endmodule

// File: rtl/adc_chan_slot.sv
// Module: one channel's result register with completion and overrun flags.
// The completion flag sets on a write and clears on a data read; a write wins.
// The overrun flag sets when a write finds the previous result unread (and not
// being read in the same cycle); it clears on a status read; a set wins.
// Assumes: wr is already qualified by the channel enable.
module adc_chan_slot #(
    parameter int unsigned RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [RES_W-1:0] wr_data,
    input  logic             data_rd,
    input  logic             stat_rd,
    output logic [RES_W-1:0] data_q,
    output logic             eoc_q,
    output logic             ovr_q
);

    // Result storage: load on every accepted completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (wr)
            data_q <= wr_data;
    end

    // Completion flag: set by write, cleared by data read, write wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eoc_q <= 1'b0;
        else if (wr)
            eoc_q <= 1'b1;
        else if (data_rd)
            eoc_q <= 1'b0;
    end

    // Overrun flag: set on an unread overwrite, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_q <= 1'b0;
        else if (wr && eoc_q && !data_rd)
            ovr_q <= 1'b1;
        else if (stat_rd)
            ovr_q <= 1'b0;
    end

endmodule

// File: rtl/adc_last_slot.sv
// Module: shared most-recent-result register with data-ready and global
// overrun flags.
// Stores the channel number next to the result so the readback identifies
// its source. Set events win over same-cycle clearing reads.
// Assumes: wr is already qualified by the channel enable.
module adc_last_slot #(
    parameter int unsigned RES_W    = 10,
    parameter int unsigned CH_IDX_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [CH_IDX_W-1:0]       wr_ch,
    input  logic [RES_W-1:0]          wr_data,
    input  logic                      last_rd,
    input  logic                      stat_rd,
    output logic [CH_IDX_W+RES_W-1:0] last_q,
    output logic                      drdy_q,
    output logic                      govr_q
);

    // Most-recent value with its channel number in the upper bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= '0;
        else if (wr)
            last_q <= {wr_ch, wr_data};
    end

    // Data-ready flag: set by any completion, cleared by a read of this register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drdy_q <= 1'b0;
        else if (wr)
            drdy_q <= 1'b1;
        else if (last_rd)
            drdy_q <= 1'b0;
    end

    // Global overrun: completion while data-ready still up and not being read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            govr_q <= 1'b0;
        else if (wr && drdy_q && !last_rd)
            govr_q <= 1'b1;
        else if (stat_rd)
            govr_q <= 1'b0;
    end

endmodule

// File: rtl/adc_result_bank.sv
// Module: ADC result bank (top).
// Accepts conversion-complete strobes, files results per channel and into a
// shared most-recent register, maintains the completion/overrun/data-ready
// status word, and serves reads with clear-on-read side effects.
// Assumes: 2*NUM_CH+2 <= 32 and CH_IDX_W+RES_W <= 32 so every register fits
// the read bus; conv_done is a single-cycle strobe.
module adc_result_bank
    import adc_res_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned RES_W  = 10,
    localparam int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned ADDR_W   = $clog2(NUM_CH + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   ch_en,
    input  logic                conv_done,
    input  logic [CH_IDX_W-1:0] conv_ch,
    input  logic [RES_W-1:0]    conv_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BUS_W-1:0]    rd_data
);

    localparam int unsigned STAT_W = 2 * NUM_CH + 2;
    localparam int unsigned LAST_W = CH_IDX_W + RES_W;

    rd_sel_e                rd_sel;
    logic [NUM_CH-1:0]      chan_rd;
    logic                   last_rd;
    logic                   stat_rd;
    logic                   conv_acc;
    logic [NUM_CH-1:0]      chan_wr;
    logic [RES_W-1:0]       chan_data [NUM_CH];
    logic [NUM_CH-1:0]      eoc_vec;
    logic [NUM_CH-1:0]      ovr_vec;
    logic [LAST_W-1:0]      last_val;
    logic                   drdy;
    logic                   govr;
    logic [STAT_W-1:0]      status;
    logic [RES_W-1:0]       sel_chan;

    // Accept a completion only for an existing, enabled channel.
    assign conv_acc = conv_done && (int'(conv_ch) < NUM_CH) && ch_en[conv_ch];

    adc_rd_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_sel  (rd_sel),
        .chan_rd (chan_rd),
        .last_rd (last_rd),
        .stat_rd (stat_rd)
    );

    // One result slot per channel.
    for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_slot
        assign chan_wr[gc] = conv_acc && (conv_ch == CH_IDX_W'(gc));

        adc_chan_slot #(
            .RES_W (RES_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (chan_wr[gc]),
            .wr_data (conv_data),
            .data_rd (chan_rd[gc]),
            .stat_rd (stat_rd),
            .data_q  (chan_data[gc]),
            .eoc_q   (eoc_vec[gc]),
            .ovr_q   (ovr_vec[gc])
        );
    end

    adc_last_slot #(
        .RES_W    (RES_W),
        .CH_IDX_W (CH_IDX_W)
    ) u_last (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (conv_acc),
        .wr_ch   (conv_ch),
        .wr_data (conv_data),
        .last_rd (last_rd),
        .stat_rd (stat_rd),
        .last_q  (last_val),
        .drdy_q  (drdy),
        .govr_q  (govr)
    );

    // Status word: completion flags, overrun flags, data-ready, global overrun.
    assign status = {govr, drdy, ovr_vec, eoc_vec};

    // Pick the channel result addressed by rd_addr.
    always_comb begin
        sel_chan = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == ADDR_W'(i))
                sel_chan = chan_data[i];
        end
    end

    // Read data multiplexer, zero-extended to the bus width.
    always_comb begin
        unique case (rd_sel)
            SEL_CHAN: rd_data = BUS_W'(sel_chan);
            SEL_LAST: rd_data = BUS_W'(last_val);
            SEL_STAT: rd_data = BUS_W'(status);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/adc_result_bank_chk.sv
// Module: assertion checker for adc_result_bank, attached by bind.
// Observes ports and the flag state; drives nothing.
module adc_result_bank_chk #(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned CH_IDX_W = 3,
    parameter int unsigned ADDR_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_CH-1:0]   ch_en,
    input logic                conv_done,
    input logic [CH_IDX_W-1:0] conv_ch,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [31:0]         rd_data,
    input logic [NUM_CH-1:0]   eoc_vec,
    input logic [NUM_CH-1:0]   ovr_vec,
    input logic                drdy,
    input logic                govr
);

    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NUM_CH + 1);

    logic acc;
    // Completion that the block should accept.
    assign acc = conv_done && ch_en[conv_ch];

    for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
        // R2
        eoc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (conv_done && conv_ch == CH_IDX_W'(gc) && ch_en[gc]) |=> eoc_vec[gc]);

        // R4
        chan_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (conv_done && conv_ch == CH_IDX_W'(gc) && ch_en[gc] && eoc_vec[gc]
             && !(rd_en && rd_addr == ADDR_W'(gc))) |=> ovr_vec[gc]);
    end

    // R5
    drdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> drdy);

    // R7
    govr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(govr) |-> ($past(acc) && $past(drdy)));

    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == STAT_A && !conv_done) |=> (ovr_vec == '0 && !govr));

    // R10
    drop_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !ch_en[conv_ch] && !rd_en)
        |=> ($stable(eoc_vec) && $stable(ovr_vec) && $stable(drdy) && $stable(govr)));

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_addr) > NUM_CH + 1) |-> (rd_data == '0));

endmodule

bind adc_result_bank adc_result_bank_chk #(
    .NUM_CH   (NUM_CH),
    .CH_IDX_W (CH_IDX_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_en     (ch_en),
    .conv_done (conv_done),
    .conv_ch   (conv_ch),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .eoc_vec   (eoc_vec),
    .ovr_vec   (ovr_vec),
    .drdy      (drdy),
    .govr      (govr)
);

// File: tb/adc_result_bank_test.sv
module adc_result_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ch_en = 8'hFF;
    logic        conv_done = 1'b0;
    logic [2:0]  conv_ch = '0;
    logic [9:0]  conv_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    logic [31:0] got;

    localparam logic [3:0] A_LAST = 4'd8;
    localparam logic [3:0] A_STAT = 4'd9;

    always #5 clk = ~clk;

    adc_result_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_en     (ch_en),
        .conv_done (conv_done),
        .conv_ch   (conv_ch),
        .conv_data (conv_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle with optional completion and optional read; returns read data.
    task automatic cyc(input logic cv, input logic [2:0] ch, input logic [9:0] d,
                       input logic rd, input logic [3:0] a, output logic [31:0] r);
        @(negedge clk);
        conv_done = cv; conv_ch = ch; conv_data = d;
        rd_en = rd; rd_addr = a;
        #1 r = rd_data;
        @(negedge clk);
        conv_done = 1'b0; rd_en = 1'b0;
    endtask

    task automatic conv(input logic [2:0] ch, input logic [9:0] d);
        logic [31:0] r;
        cyc(1'b1, ch, d, 1'b0, 4'd0, r);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] r);
        cyc(1'b0, 3'd0, 10'd0, 1'b1, a, r);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 10; i++) begin
            rd(4'(i), got);
            check("R1 reset", got, 32'h0);
        end
    endtask

    task automatic t_basic;
        conv(3'd3, 10'h2A5);
        rd(A_STAT, got); check("R2 eoc+drdy", got, 32'h0001_0008);
        rd(4'd3, got);   check("R3 chan read", got, 32'h2A5);
        rd(A_STAT, got); check("R3 eoc cleared", got, 32'h0001_0000);
        rd(A_LAST, got); check("R5 last readback", got, 32'h0EA5);
        rd(A_STAT, got); check("R6 drdy cleared", got, 32'h0);
        conv(3'd7, 10'h3FF);
        rd(A_LAST, got); check("R5 top channel", got, 32'h1FFF);
        rd(4'd7, got);   check("R3 full scale", got, 32'h3FF);
    endtask

    task automatic t_overrun;
        conv(3'd5, 10'h111);
        conv(3'd5, 10'h222);
        rd(A_STAT, got); check("R4 R7 overruns", got, 32'h0003_2020);
        rd(A_STAT, got); check("R8 status clears overruns", got, 32'h0001_0020);
        rd(4'd5, got);   check("R2 newest kept", got, 32'h222);
        rd(A_LAST, got); check("R5 last ch5", got, 32'h1622);
        rd(A_STAT, got); check("R6 all clear", got, 32'h0);
    endtask

    task automatic t_same_data_read;
        conv(3'd2, 10'h0AA);
        cyc(1'b1, 3'd2, 10'h155, 1'b1, 4'd2, got);
        check("R3 old value read", got, 32'h0AA);
        rd(A_STAT, got); check("R4 R9 no chan ovr, eoc kept", got, 32'h0003_0004);
        rd(4'd2, got);   check("R2 new value", got, 32'h155);
        rd(A_LAST, got); check("R5 last ch2", got, 32'h0955);
        rd(A_STAT, got); check("R8 clean", got, 32'h0);
    endtask

    task automatic t_same_stat_read;
        conv(3'd1, 10'h001);
        conv(3'd1, 10'h002);
        cyc(1'b1, 3'd1, 10'h003, 1'b1, A_STAT, got);
        check("R8 status returned", got, 32'h0003_0202);
        rd(A_STAT, got); check("R9 set wins over status read", got, 32'h0003_0202);
        rd(A_STAT, got); check("R8 cleared after", got, 32'h0001_0002);
        rd(4'd1, got);   check("R3 ch1", got, 32'h003);
        rd(A_LAST, got); check("R5 last ch1", got, 32'h0403);
        cyc(1'b1, 3'd0, 10'h3FF, 1'b1, A_LAST, got);
        check("R6 old last read", got, 32'h0403);
        rd(A_STAT, got); check("R9 R7 drdy set wins, no govr", got, 32'h0001_0001);
        rd(4'd0, got);   check("R3 ch0", got, 32'h3FF);
        rd(A_LAST, got); check("R5 last ch0", got, 32'h03FF);
    endtask

    task automatic t_disabled;
        ch_en = 8'hBF;
        conv(3'd6, 10'h123);
        rd(A_STAT, got); check("R10 no flags", got, 32'h0);
        rd(4'd6, got);   check("R10 no data", got, 32'h0);
        rd(A_LAST, got); check("R10 last unchanged", got, 32'h03FF);
        ch_en = 8'hFF;
    endtask

    task automatic t_unmapped;
        conv(3'd4, 10'h0F0);
        rd(4'd10, got);  check("R11 addr10 zero", got, 32'h0);
        rd(4'd15, got);  check("R11 addr15 zero", got, 32'h0);
        cyc(1'b0, 3'd0, 10'd0, 1'b0, 4'd4, got);
        cyc(1'b0, 3'd0, 10'd0, 1'b0, A_LAST, got);
        rd(A_STAT, got); check("R11 nothing cleared", got, 32'h0001_0010);
        rd(4'd4, got);   check("R3 ch4", got, 32'h0F0);
        rd(A_LAST, got); check("R5 last ch4", got, 32'h10F0);
        rd(A_STAT, got); check("R6 final clear", got, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_basic;
        t_overrun;
        t_same_data_read;
        t_same_stat_read;
        t_disabled;
        t_unmapped;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule